// File: doc/BRIEF.md
# Debug Transaction Status Checker

This controller confirms that a batch of previously queued debug-port transactions finished cleanly. On a start pulse it drives a sequence of single operations into a downstream register access engine: it posts a read of the debug port's control/status register, then collects the posted result through the read buffer. It classifies the acknowledge of that collect, retries while the target answers WAIT, and gives up with an abort write once a cycle-count timeout has elapsed. An acknowledge that is neither OK/FAULT nor WAIT ends the check at once with an error.

When the collected status word shows a sticky overrun or sticky error flag, the controller writes the requester's control value back with both sticky bits set, which clears them, and reads the status word again. It then reads the memory access port's control word and transfer address for diagnosis. A status word whose four power-acknowledge bits are not all set is flagged so the requester can reinitialise the debug domains; the controller does not do that itself. Completion, the error cause and the captured words stay visible until the next start.

Top module: `dbg_status_check`

## Requirements
- R1: Only the low three bits of `rsp_ack` classify an acknowledge: 3'b010 is OK/FAULT, 3'b001 is WAIT, anything else is invalid; the upper bits have no effect.
- R2: Each attempt issues a posted status read (`op_ir`=4'hA, `op_addr`=4'h4, `op_rnw`=1, `op_wdata`=0) then a collect (`op_ir`=4'hA, `op_addr`=4'hC, `op_rnw`=1); an OK collect whose data has bits 1 and 5 clear ends with `done`=1, `error`=0 and `status_word` equal to the collected data.
- R3: A WAIT collect received while the elapsed cycle count since start is below CLK_KHZ*TIMEOUT_MS starts a new attempt with a posted status read.
- R4: A WAIT collect received once the elapsed count has reached CLK_KHZ*TIMEOUT_MS issues exactly one abort (`op_ir`=4'h8, `op_addr`=0, `op_rnw`=0, `op_wdata`=1); its response ends the check with `done`, `error` and `timed_out` set.
- R5: An invalid acknowledge on a collect ends the check with `done`, `error` and `bad_ack` set, and no further operation is issued.
- R6: When the OK collect shows bit 1 (sticky overrun) or bit 5 (sticky error), the controller writes `ctrl_base` with bits 1 and 5 set (`op_ir`=4'hA, `op_addr`=4'h4, `op_rnw`=0), then posts and collects the status word again; `status_word` holds the re-read value.
- R7: After the sticky clear it reads the access port control word (`op_ir`=4'hB, `op_addr`=4'h0), the transfer address (`op_ir`=4'hB, `op_addr`=4'h4) and drains the read buffer (4'hA, 4'hC); the second and third responses' data appear on `diag_csw` and `diag_tar`, and the check ends with `error` and `sticky_seen` set.
- R8: `pwr_low` is set when a sticky flag was seen and bits [31:28] of the first OK status word are not all ones; otherwise it is clear.
- R9: `done`, `error` and the cause flags hold until the next start; a start while busy is ignored; a start while idle clears them.
- R10: `op_valid` is a one-cycle pulse and no new operation is issued until the previous one has received `rsp_valid`.
- R11: After reset `busy`, `done`, `error`, all flags and `op_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (acted on only when idle) |
| ctrl_base | input | 32 | Control value written back when clearing sticky flags |
| op_valid | output | 1 | One-cycle request to the access engine |
| op_ir | output | 4 | Scan instruction: 4'hA debug port, 4'hB access port, 4'h8 abort |
| op_addr | output | 4 | Register address, bits [3:2] significant |
| op_rnw | output | 1 | 1 read, 0 write |
| op_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Engine response for the outstanding operation |
| rsp_ack | input | ACK_IN_W | Raw acknowledge from the engine |
| rsp_rdata | input | 32 | Data captured by the operation |
| busy | output | 1 | A check is in progress |
| done | output | 1 | Check finished (sticky) |
| error | output | 1 | Check finished with an error (sticky) |
| timed_out | output | 1 | Ended by WAIT timeout and abort |
| bad_ack | output | 1 | Ended by an invalid acknowledge |
| sticky_seen | output | 1 | Sticky overrun or error flag was found and cleared |
| pwr_low | output | 1 | Debug power domains need reinitialisation |
| status_word | output | 32 | Last collected control/status value |
| diag_csw | output | 32 | Access port control word read after a sticky error |
| diag_tar | output | 32 | Access port transfer address read after a sticky error |

## Verification
The bench plays the access engine and predicts every operation from its own model of the sequence, so a design that collected before posting, used the wrong address or instruction, or issued a second request before the response would be caught at the op it got wrong. The timeout boundary is predicted from the bench's own cycle count at each WAIT response, so an off-by-one in the timer shows up as one attempt too many or too few before the abort. Acknowledges with upper bits set catch a design that compares the full raw field, and a status word carrying an unrelated bit catches a sticky mask that is too wide. A start pulse injected mid-run and a hold period after completion catch a design that restarts while busy or lets done drop on its own.

// File: rtl/dbg_chk_pkg.sv
package dbg_chk_pkg;

    // Scan instructions selected toward the access engine
    localparam logic [3:0] IR_ABORT = 4'h8;
    localparam logic [3:0] IR_DPACC = 4'hA;
    localparam logic [3:0] IR_APACC = 4'hB;

    // Register addresses (bits [3:2] significant)
    localparam logic [3:0] AD_STATUS = 4'h4;
    localparam logic [3:0] AD_RDBUF  = 4'hC;
    localparam logic [3:0] AD_APCSW  = 4'h0;
    localparam logic [3:0] AD_APTAR  = 4'h4;

    localparam int ORUN_BIT = 1;
    localparam int SERR_BIT = 5;
    localparam logic [31:0] STICKY_MASK = (32'h1 << ORUN_BIT) | (32'h1 << SERR_BIT);
    localparam logic [3:0]  PWR_ALL_ON  = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_POST       = 4'd1,
        ST_COLLECT    = 4'd2,
        ST_ABORT      = 4'd3,
        ST_CLEAR      = 4'd4,
        ST_RB_POST    = 4'd5,
        ST_RB_COLLECT = 4'd6,
        ST_AP_CSW     = 4'd7,
        ST_AP_TAR     = 4'd8,
        ST_AP_DRAIN   = 4'd9
    } step_e;

    typedef enum logic [1:0] {
        ACK_OK   = 2'd0,
        ACK_WAIT = 2'd1,
        ACK_BAD  = 2'd2
    } ack_cls_e;

    typedef struct packed {
        logic [3:0]  ir;
        logic [3:0]  addr;
        logic        rnw;
        logic [31:0] wdata;
    } dbg_op_t;

    typedef struct packed {
        step_e       step;
        logic        waiting;
        logic        done;
        logic        err;
        logic        tmo;
        logic        bad;
        logic        sticky;
        logic        pwr;
        logic [31:0] cs;
        logic [31:0] csw;
        logic [31:0] tar;
    } chk_state_t;

endpackage

// File: rtl/dbg_ack_classify.sv
module dbg_ack_classify
    import dbg_chk_pkg::*;
#(
    parameter int unsigned ACK_IN_W = 4
) (
    input  logic [ACK_IN_W-1:0] ack_raw,
    output ack_cls_e            ack_cls
);
    localparam logic [ACK_IN_W-1:0] LOW_MASK  = ACK_IN_W'(3'b111);
    localparam logic [ACK_IN_W-1:0] CODE_OK   = ACK_IN_W'(3'b010);
    localparam logic [ACK_IN_W-1:0] CODE_WAIT = ACK_IN_W'(3'b001);

    logic [ACK_IN_W-1:0] masked;

    always_comb begin
        masked = ack_raw & LOW_MASK;
        if (masked == CODE_OK) begin
            ack_cls = ACK_OK;
        end else if (masked == CODE_WAIT) begin
            ack_cls = ACK_WAIT;
        end else begin
            ack_cls = ACK_BAD;
        end
    end
endmodule

// File: rtl/dbg_op_table.sv
module dbg_op_table
    import dbg_chk_pkg::*;
(
    input  step_e       step,
    input  logic [31:0] ctrl_base,
    output dbg_op_t     op
);
    always_comb begin
        op = '{ir: IR_DPACC, addr: AD_STATUS, rnw: 1'b1, wdata: 32'h0};
        unique case (step)
            ST_POST, ST_RB_POST: begin
                op.ir   = IR_DPACC;
                op.addr = AD_STATUS;
            end
            ST_COLLECT, ST_RB_COLLECT, ST_AP_DRAIN: begin
                op.ir   = IR_DPACC;
                op.addr = AD_RDBUF;
            end
            ST_ABORT: begin
                op.ir    = IR_ABORT;
                op.addr  = 4'h0;
                op.rnw   = 1'b0;
                op.wdata = 32'h1;
            end
            ST_CLEAR: begin
                op.ir    = IR_DPACC;
                op.addr  = AD_STATUS;
                op.rnw   = 1'b0;
                op.wdata = ctrl_base | STICKY_MASK;
            end
            ST_AP_CSW: begin
                op.ir   = IR_APACC;
                op.addr = AD_APCSW;
            end
            ST_AP_TAR: begin
                op.ir   = IR_APACC;
                op.addr = AD_APTAR;
            end
            default: begin
                op.ir   = IR_DPACC;
                op.addr = AD_STATUS;
            end
        endcase
    end
endmodule

// File: rtl/dbg_wait_timer.sv
module dbg_wait_timer #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q >= LIM);
endmodule

// File: rtl/dbg_status_check.sv
module dbg_status_check
    import dbg_chk_pkg::*;
#(
    parameter int unsigned ACK_IN_W   = 4,
    parameter int unsigned CLK_KHZ    = 4,
    parameter int unsigned TIMEOUT_MS = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         ctrl_base,
    output logic                op_valid,
    output logic [3:0]          op_ir,
    output logic [3:0]          op_addr,
    output logic                op_rnw,
    output logic [31:0]         op_wdata,
    input  logic                rsp_valid,
    input  logic [ACK_IN_W-1:0] rsp_ack,
    input  logic [31:0]         rsp_rdata,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic                timed_out,
    output logic                bad_ack,
    output logic                sticky_seen,
    output logic                pwr_low,
    output logic [31:0]         status_word,
    output logic [31:0]         diag_csw,
    output logic [31:0]         diag_tar
);
    localparam int unsigned TIMEOUT_CYC = CLK_KHZ * TIMEOUT_MS;

    chk_state_t s_d, s_q;
    ack_cls_e   cls;
    logic       expired;
    logic       is_idle;
    dbg_op_t    op;

    assign is_idle = (s_q.step == ST_IDLE);

    dbg_ack_classify #(.ACK_IN_W(ACK_IN_W)) u_cls (
        .ack_raw (rsp_ack),
        .ack_cls (cls)
    );

    dbg_op_table u_tab (
        .step      (s_q.step),
        .ctrl_base (ctrl_base),
        .op        (op)
    );

    dbg_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (is_idle && start),
        .run     (!is_idle),
        .expired (expired)
    );

    always_comb begin
        s_d = s_q;
        if (!is_idle && !s_q.waiting) begin
            s_d.waiting = 1'b1;
        end
        if (is_idle) begin
            if (start) begin
                s_d.step    = ST_POST;
                s_d.waiting = 1'b0;
                s_d.done    = 1'b0;
                s_d.err     = 1'b0;
                s_d.tmo     = 1'b0;
                s_d.bad     = 1'b0;
                s_d.sticky  = 1'b0;
                s_d.pwr     = 1'b0;
            end
        end else if (s_q.waiting && rsp_valid) begin
            s_d.waiting = 1'b0;
            unique case (s_q.step)
                ST_POST: s_d.step = ST_COLLECT;
                ST_COLLECT: begin
                    unique case (cls)
                        ACK_OK: begin
                            s_d.cs = rsp_rdata;
                            if ((rsp_rdata & STICKY_MASK) != 32'h0) begin
                                s_d.sticky = 1'b1;
                                s_d.pwr    = (rsp_rdata[31:28] != PWR_ALL_ON);
                                s_d.step   = ST_CLEAR;
                            end else begin
                                s_d.step = ST_IDLE;
                                s_d.done = 1'b1;
                            end
                        end
                        ACK_WAIT: begin
                            s_d.step = expired ? ST_ABORT : ST_POST;
                        end
                        default: begin
                            s_d.bad  = 1'b1;
                            s_d.err  = 1'b1;
                            s_d.done = 1'b1;
                            s_d.step = ST_IDLE;
                        end
                    endcase
                end
                ST_ABORT: begin
                    s_d.tmo  = 1'b1;
                    s_d.err  = 1'b1;
                    s_d.done = 1'b1;
                    s_d.step = ST_IDLE;
                end
                ST_CLEAR:   s_d.step = ST_RB_POST;
                ST_RB_POST: s_d.step = ST_RB_COLLECT;
                ST_RB_COLLECT: begin
                    s_d.cs   = rsp_rdata;
                    s_d.step = ST_AP_CSW;
                end
                ST_AP_CSW: s_d.step = ST_AP_TAR;
                ST_AP_TAR: begin
                    s_d.csw  = rsp_rdata;
                    s_d.step = ST_AP_DRAIN;
                end
                ST_AP_DRAIN: begin
                    s_d.tar  = rsp_rdata;
                    s_d.err  = 1'b1;
                    s_d.done = 1'b1;
                    s_d.step = ST_IDLE;
                end
                default: s_d.step = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_valid    = !is_idle && !s_q.waiting;
    assign op_ir       = op.ir;
    assign op_addr     = op.addr;
    assign op_rnw      = op.rnw;
    assign op_wdata    = op.wdata;
    assign busy        = !is_idle;
    assign done        = s_q.done;
    assign error       = s_q.err;
    assign timed_out   = s_q.tmo;
    assign bad_ack     = s_q.bad;
    assign sticky_seen = s_q.sticky;
    assign pwr_low     = s_q.pwr;
    assign status_word = s_q.cs;
    assign diag_csw    = s_q.csw;
    assign diag_tar    = s_q.tar;
endmodule

// File: rtl/dbg_status_check_sva.sv
module dbg_status_check_sva
    import dbg_chk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        op_valid,
    input logic [3:0]  op_ir,
    input logic [3:0]  op_addr,
    input logic        op_rnw,
    input logic [31:0] op_wdata,
    input logic        rsp_valid,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic        timed_out,
    input logic        bad_ack,
    input logic        sticky_seen,
    input logic        pwr_low
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (op_valid) begin
            pend_q <= 1'b1;
        end else if (rsp_valid) begin
            pend_q <= 1'b0;
        end
    end

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !pend_q);

    assert_op_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);

    assert_abort_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ir == IR_ABORT) |-> (!op_rnw && op_addr == 4'h0 && op_wdata == 32'h1));

    assert_timeout_is_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> (error && !bad_ack));

    assert_badack_is_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ack |-> error);

    assert_pwr_needs_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_low |-> sticky_seen);

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dbg_status_check dbg_status_check_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .op_valid    (op_valid),
    .op_ir       (op_ir),
    .op_addr     (op_addr),
    .op_rnw      (op_rnw),
    .op_wdata    (op_wdata),
    .rsp_valid   (rsp_valid),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .timed_out   (timed_out),
    .bad_ack     (bad_ack),
    .sticky_seen (sticky_seen),
    .pwr_low     (pwr_low)
);

// File: tb/sim_dbg_status_check.sv
module sim_dbg_status_check;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int T_CYC      = 100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] ctrl_base;
    logic        op_valid;
    logic [3:0]  op_ir;
    logic [3:0]  op_addr;
    logic        op_rnw;
    logic [31:0] op_wdata;
    logic        rsp_valid;
    logic [3:0]  rsp_ack;
    logic [31:0] rsp_rdata;
    logic        busy, done, error, timed_out, bad_ack, sticky_seen, pwr_low;
    logic [31:0] status_word, diag_csw, diag_tar;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbg_status_check #(.ACK_IN_W(4), .CLK_KHZ(4), .TIMEOUT_MS(25)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_base(ctrl_base),
        .op_valid(op_valid), .op_ir(op_ir), .op_addr(op_addr), .op_rnw(op_rnw),
        .op_wdata(op_wdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_rdata(rsp_rdata), .busy(busy), .done(done), .error(error),
        .timed_out(timed_out), .bad_ack(bad_ack), .sticky_seen(sticky_seen),
        .pwr_low(pwr_low), .status_word(status_word), .diag_csw(diag_csw),
        .diag_tar(diag_tar)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected operation for each model phase, packed {ir, addr, rnw, wdata}
    function automatic logic [40:0] exp_op(input int ph, input logic [31:0] base);
        case (ph)
            0, 4:    return {4'hA, 4'h4, 1'b1, 32'h0};
            1, 5, 8: return {4'hA, 4'hC, 1'b1, 32'h0};
            2:       return {4'h8, 4'h0, 1'b0, 32'h1};
            3:       return {4'hA, 4'h4, 1'b0, base | 32'h22};
            6:       return {4'hB, 4'h0, 1'b1, 32'h0};
            default: return {4'hB, 4'h4, 1'b1, 32'h0};
        endcase
    endfunction

    function automatic string ph_tag(input int ph);
        case (ph)
            0, 1:    return "R2 op";
            2:       return "R4 abort op";
            3, 4, 5: return "R6 clear op";
            default: return "R7 diag op";
        endcase
    endfunction

    // waits < 0 means the target answers WAIT forever
    task automatic run_case(input string name, input int waits, input logic [3:0] fin_ack,
                            input logic [31:0] cs0, input logic [31:0] rb,
                            input logic [31:0] cswv, input logic [31:0] tarv,
                            input logic [31:0] base, input bit poke);
        int ph = 0;
        int wl = waits;
        int guard;
        bit poked = 1'b0;
        bit e_err = 0, e_tmo = 0, e_bad = 0, e_stk = 0, e_pwr = 0;
        logic [31:0] e_cs = 32'h0;
        ctrl_base = base;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        chk({name, " R9 start clears done"}, {63'h0, done}, 64'h0);
        chk({name, " busy after start"}, {63'h0, busy}, 64'h1);
        while (ph != 9) begin
            guard = 0;
            while (!op_valid && guard < 40) begin
                if (done !== 1'b0) chk({name, " R9 done early"}, {63'h0, done}, 64'h0);
                @(negedge clk);
                cyc++;
                guard++;
            end
            if (!op_valid) begin
                chk({name, " R10 expected an op"}, 64'h0, 64'h1);
                break;
            end
            chk({name, " ", ph_tag(ph)}, {23'h0, op_ir, op_addr, op_rnw, op_wdata},
                {23'h0, exp_op(ph, base)});
            if (poke && !poked) begin
                start = 1'b1;
                poked = 1'b1;
            end
            for (int i = 0; i < LAT; i++) begin
                @(negedge clk);
                cyc++;
                start = 1'b0;
                if (op_valid !== 1'b0) chk({name, " R10 op while outstanding"}, 64'h1, 64'h0);
            end
            rsp_valid = 1'b1;
            rsp_ack   = 4'h2;
            rsp_rdata = 32'h0;
            case (ph)
                0: ph = 1;
                1: begin
                    if (wl != 0) begin
                        rsp_ack   = 4'h1;
                        rsp_rdata = 32'hDEAD_0022;
                        if (wl > 0) wl--;
                        ph = (cyc >= T_CYC) ? 2 : 0;
                    end else begin
                        rsp_ack   = fin_ack;
                        rsp_rdata = cs0;
                        if (fin_ack[2:0] == 3'b010) begin
                            e_cs = cs0;
                            if (cs0[1] || cs0[5]) begin
                                e_stk = 1; e_err = 1;
                                e_pwr = (cs0[31:28] != 4'hF);
                                ph = 3;
                            end else begin
                                ph = 9;
                            end
                        end else begin
                            e_bad = 1; e_err = 1;
                            ph = 9;
                        end
                    end
                end
                2: begin e_tmo = 1; e_err = 1; ph = 9; end
                5: begin rsp_rdata = rb; e_cs = rb; ph = 6; end
                7: begin rsp_rdata = cswv; ph = 8; end
                8: begin rsp_rdata = tarv; ph = 9; end
                default: ph = ph + 1;
            endcase
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            rsp_ack   = 4'h0;
            rsp_rdata = 32'h0;
        end
        chk({name, " R9 done"},        {63'h0, done},        64'h1);
        chk({name, " busy idle"},      {63'h0, busy},        64'h0);
        chk({name, " error"},          {63'h0, error},       {63'h0, e_err});
        chk({name, " R4 timed_out"},   {63'h0, timed_out},   {63'h0, e_tmo});
        chk({name, " R5 bad_ack"},     {63'h0, bad_ack},     {63'h0, e_bad});
        chk({name, " R6 sticky_seen"}, {63'h0, sticky_seen}, {63'h0, e_stk});
        chk({name, " R8 pwr_low"},     {63'h0, pwr_low},     {63'h0, e_pwr});
        if (!e_tmo && !e_bad) chk({name, " R2 status_word"}, {32'h0, status_word}, {32'h0, e_cs});
        if (e_stk) begin
            chk({name, " R7 diag_csw"}, {32'h0, diag_csw}, {32'h0, cswv});
            chk({name, " R7 diag_tar"}, {32'h0, diag_tar}, {32'h0, tarv});
        end
        repeat (5) @(negedge clk);
        chk({name, " R9 done held"},  {63'h0, done},     64'h1);
        chk({name, " R9 error held"}, {63'h0, error},    {63'h0, e_err});
        chk({name, " R10 no stray op"}, {63'h0, op_valid}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; ctrl_base = 32'h0;
        rsp_valid = 1'b0; rsp_ack = 4'h0; rsp_rdata = 32'h0;
        repeat (3) @(negedge clk);
        chk("R11 reset busy",     {63'h0, busy},        64'h0);
        chk("R11 reset done",     {63'h0, done},        64'h0);
        chk("R11 reset error",    {63'h0, error},       64'h0);
        chk("R11 reset op_valid", {63'h0, op_valid},    64'h0);
        chk("R11 reset flags",    {59'h0, timed_out, bad_ack, sticky_seen, pwr_low, 1'b0}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case("R2 clean",           0, 4'h2, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        run_case("R1 R3 wait retry",   3, 4'hA, 32'hF000_0040, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        run_case("R4 timeout",        -1, 4'h2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        run_case("R5 bad ack 100",     0, 4'h4, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        run_case("R1 R5 bad ack 111",  1, 4'hF, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        run_case("R1 R5 bad ack 000",  0, 4'h8, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        run_case("R6 R7 overrun",      0, 4'h2, 32'hF000_0002, 32'hF000_0000,
                 32'hA200_0012, 32'h2000_1000, 32'h5000_0000, 1'b0);
        run_case("R7 R8 sticky err",   1, 4'h2, 32'h3000_0020, 32'h3000_0000,
                 32'h0300_0002, 32'h0000_0BEC, 32'h0000_0F00, 1'b0);
        run_case("R9 start while busy", 2, 4'h2, 32'hF000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule